// File: doc/BRIEF.md
# PC-Relative Address Unit

This unit executes the group of operations that form a value or a memory address from the current program counter. A single 21-bit field carries both the sub-operation and its offset. The unit reads a 5-bit prefix of that field first, then a 3-bit prefix, then a 2-bit prefix. Each sub-operation takes an offset of its own width and scales it in its own way. Three of the forms are pure arithmetic: add a scaled 19-bit offset, add an upper 16-bit offset, and add an upper 16-bit offset then clear the low half-word. Three of the forms are loads: a sign-extending word load, a zero-extending word load, and a doubleword load.

The result goes to the register whose index arrives with the strobe. An arithmetic form writes that register one cycle after the strobe. A load issues a one-cycle read request in the cycle after the strobe and raises `busy`. It writes the destination in the cycle after the memory response arrives. Only one load is outstanding at a time.

Top module: `pcrel_unit`

## Requirements
- R1: After reset, `wr_en`, `illegal`, `mem_req_valid` and `busy` are all low.
- R2: When `op_field[20:16]` is 5'b11110, the unit writes `op_pc + (sign-extended op_field[15:0] << 16)` to `op_dst` one cycle after the strobe.
- R3: When `op_field[20:16]` is 5'b11111, the unit computes the same sum as R2 with bits 15:0 cleared and writes it one cycle after the strobe.
- R4: When `op_field[20:19]` is 2'b00, the unit writes `op_pc + (sign-extended op_field[18:0] << 2)` one cycle after the strobe.
- R5: When `op_field[20:19]` is 2'b01, the unit issues a read one cycle after the strobe, at the address of R4 with `mem_req_dword` = 0. The written value is bits 31:0 of the response, sign-extended.
- R6: When `op_field[20:19]` is 2'b10, the unit issues the same read as R5, and the written value is bits 31:0 of the response, zero-extended.
- R7: When `op_field[20:18]` is 3'b110 and R2/R3 do not match, the unit issues a read at `(op_pc with bits 2:0 cleared) + (sign-extended op_field[17:0] << 3)` with `mem_req_dword` = 1. The written value is all 64 response bits.
- R8: When `op_field[20:16]` is 5'b11100 or 5'b11101, `illegal` pulses for one cycle after the strobe, and there is no write and no request.
- R9: `busy` is high from the cycle after a load strobe until the response. A strobe taken while busy causes no write, no request and no illegal pulse.
- R10: A response while busy produces a write in the next cycle, to the index captured with the load. `busy` falls in that same cycle.
- R11: Without a strobe or a pending load response, `wr_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_pc | input | 64 | Program counter of the operation |
| op_field | input | 21 | Sub-operation prefix and offset |
| op_dst | input | 5 | Destination register index |
| busy | output | 1 | A load is outstanding |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | 5 | Destination index |
| wr_data | output | 64 | Destination value |
| illegal | output | 1 | Unmatched prefix pulse |
| mem_req_valid | output | 1 | Read request pulse |
| mem_req_addr | output | 64 | Read address |
| mem_req_dword | output | 1 | 1 = 64-bit read, 0 = 32-bit read |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 64 | Read response data |

## Verification
The assertions assume that memory answers each request exactly once, never before the request pulse, and that responses outside a pending load do not occur. The bench raises the response only after it has seen the request and `busy`, and keeps it high for one cycle. The bench also issues one strobe during a pending load to show that the unit drops it, but it never issues a response without an outstanding request.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;

    localparam int FIELD_W = 21;

    // prefix values the decode depends on
    localparam logic [4:0] PFX5_UPPER   = 5'b11110;
    localparam logic [4:0] PFX5_UPPER_A = 5'b11111;
    localparam logic [2:0] PFX3_DWORD   = 3'b110;
    localparam logic [1:0] PFX2_ADD     = 2'b00;
    localparam logic [1:0] PFX2_WORD_S  = 2'b01;
    localparam logic [1:0] PFX2_WORD_U  = 2'b10;

    typedef enum logic [2:0] {
        OP_BAD    = 3'd0,
        OP_ADD    = 3'd1,
        OP_UPPER  = 3'd2,
        OP_UPPERA = 3'd3,
        OP_LDW_S  = 3'd4,
        OP_LDW_U  = 3'd5,
        OP_LDD    = 3'd6
    } pc_op_e;

    function automatic logic op_is_load(pc_op_e op);
        return (op == OP_LDW_S) || (op == OP_LDW_U) || (op == OP_LDD);
    endfunction

endpackage

// File: rtl/pcrel_decode.sv
module pcrel_decode
    import pcrel_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    output pc_op_e             op
);
    logic [4:0] p5;
    logic [2:0] p3;
    logic [1:0] p2;

    assign p5 = field[FIELD_W-1 -: 5];
    assign p3 = field[FIELD_W-1 -: 3];
    assign p2 = field[FIELD_W-1 -: 2];

    // longest prefix is examined first, then shorter ones
    always_comb begin
        if (p5 == PFX5_UPPER)        op = OP_UPPER;
        else if (p5 == PFX5_UPPER_A) op = OP_UPPERA;
        else if (p3 == PFX3_DWORD)   op = OP_LDD;
        else if (p2 == PFX2_ADD)     op = OP_ADD;
        else if (p2 == PFX2_WORD_S)  op = OP_LDW_S;
        else if (p2 == PFX2_WORD_U)  op = OP_LDW_U;
        else                         op = OP_BAD;
    end

    // R8: only the 1110x prefixes fall through to illegal
    always_comb begin
        if (op == OP_BAD)
            p_bad_prefix_r8: assert (p5 == 5'b11100 || p5 == 5'b11101);
    end

endmodule

// File: rtl/pcrel_addr_gen.sv
module pcrel_addr_gen
    import pcrel_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]    pc,
    input  logic [FIELD_W-1:0] field,
    input  pc_op_e             op,
    output logic [XLEN-1:0]    value,
    output logic [XLEN-1:0]    addr
);
    localparam int UPPER_SH = 16;
    localparam int WORD_SH  = 2;
    localparam int DWORD_SH = 3;
    localparam int OFF19_W  = 19;
    localparam int OFF18_W  = 18;
    localparam int OFF16_W  = 16;

    logic [XLEN-1:0] sx16, sx19, sx18;
    logic [XLEN-1:0] upper_sum, upper_alg, rel_word, rel_dword, pc_dalign;

    assign sx16 = {{(XLEN-OFF16_W){field[OFF16_W-1]}}, field[OFF16_W-1:0]};
    assign sx19 = {{(XLEN-OFF19_W){field[OFF19_W-1]}}, field[OFF19_W-1:0]};
    assign sx18 = {{(XLEN-OFF18_W){field[OFF18_W-1]}}, field[OFF18_W-1:0]};

    assign upper_sum = pc + (sx16 << UPPER_SH);
    assign upper_alg = {upper_sum[XLEN-1:UPPER_SH], {UPPER_SH{1'b0}}};
    assign rel_word  = pc + (sx19 << WORD_SH);
    assign pc_dalign = {pc[XLEN-1:DWORD_SH], {DWORD_SH{1'b0}}};
    assign rel_dword = pc_dalign + (sx18 << DWORD_SH);

    always_comb begin
        unique case (op)
            OP_UPPER:  value = upper_sum;
            OP_UPPERA: value = upper_alg;
            default:   value = rel_word;
        endcase
        addr = (op == OP_LDD) ? rel_dword : rel_word;
    end

    // R7: the doubleword address is naturally aligned
    always_comb begin
        if (op == OP_LDD)
            p_dword_align_r7: assert (addr[DWORD_SH-1:0] == '0);
    end

endmodule

// File: rtl/pcrel_load_fmt.sv
module pcrel_load_fmt
    import pcrel_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  pc_op_e          kind,
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] data
);
    localparam int WORD_W = 32;

    always_comb begin
        unique case (kind)
            OP_LDW_S: data = {{(XLEN-WORD_W){raw[WORD_W-1]}}, raw[WORD_W-1:0]};
            OP_LDW_U: data = {{(XLEN-WORD_W){1'b0}}, raw[WORD_W-1:0]};
            default:  data = raw;
        endcase
    end

    // R6: a zero-extended word carries no upper bits
    always_comb begin
        if (kind == OP_LDW_U)
            p_zext_upper_r6: assert (data[XLEN-1:WORD_W] == '0);
    end

endmodule

// File: rtl/pcrel_unit.sv
module pcrel_unit
    import pcrel_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [XLEN-1:0]    op_pc,
    input  logic [FIELD_W-1:0] op_field,
    input  logic [IDX_W-1:0]   op_dst,
    output logic               busy,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [XLEN-1:0]    wr_data,
    output logic               illegal,
    output logic               mem_req_valid,
    output logic [XLEN-1:0]    mem_req_addr,
    output logic               mem_req_dword,
    input  logic               mem_rsp_valid,
    input  logic [XLEN-1:0]    mem_rsp_data
);
    typedef struct packed {
        logic             busy;
        pc_op_e           kind;
        logic [IDX_W-1:0] dst;
        logic             wr_en;
        logic [IDX_W-1:0] wr_idx;
        logic [XLEN-1:0]  wr_data;
        logic             illegal;
        logic             req_valid;
        logic [XLEN-1:0]  req_addr;
        logic             req_dword;
    } state_t;

    state_t st_d, st_q;

    pc_op_e          dec_op;
    logic [XLEN-1:0] calc_value;
    logic [XLEN-1:0] calc_addr;
    logic [XLEN-1:0] ld_data;

    pcrel_decode i_decode (
        .field (op_field),
        .op    (dec_op)
    );

    pcrel_addr_gen #(.XLEN(XLEN)) i_addr_gen (
        .pc    (op_pc),
        .field (op_field),
        .op    (dec_op),
        .value (calc_value),
        .addr  (calc_addr)
    );

    pcrel_load_fmt #(.XLEN(XLEN)) i_load_fmt (
        .kind (st_q.kind),
        .raw  (mem_rsp_data),
        .data (ld_data)
    );

    always_comb begin
        st_d           = st_q;
        st_d.wr_en     = 1'b0;
        st_d.illegal   = 1'b0;
        st_d.req_valid = 1'b0;
        if (st_q.busy) begin
            if (mem_rsp_valid) begin
                st_d.busy    = 1'b0;
                st_d.wr_en   = 1'b1;
                st_d.wr_idx  = st_q.dst;
                st_d.wr_data = ld_data;
            end
        end else if (op_valid) begin
            if (dec_op == OP_BAD) begin
                st_d.illegal = 1'b1;
            end else if (op_is_load(dec_op)) begin
                st_d.busy      = 1'b1;
                st_d.kind      = dec_op;
                st_d.dst       = op_dst;
                st_d.req_valid = 1'b1;
                st_d.req_addr  = calc_addr;
                st_d.req_dword = (dec_op == OP_LDD);
            end else begin
                st_d.wr_en   = 1'b1;
                st_d.wr_idx  = op_dst;
                st_d.wr_data = calc_value;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy          = st_q.busy;
    assign wr_en         = st_q.wr_en;
    assign wr_idx        = st_q.wr_idx;
    assign wr_data       = st_q.wr_data;
    assign illegal       = st_q.illegal;
    assign mem_req_valid = st_q.req_valid;
    assign mem_req_addr  = st_q.req_addr;
    assign mem_req_dword = st_q.req_dword;

    p_req_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    p_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    p_rsp_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rsp_valid) |=> (wr_en && !busy));

    p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && !mem_req_valid && !busy));

    p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !(busy && mem_rsp_valid)) |=> !wr_en);

endmodule

// File: tb/test_pcrel_unit.sv
module test_pcrel_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [63:0] op_pc = '0;
    logic [20:0] op_field = '0;
    logic [4:0]  op_dst = '0;
    logic        busy, wr_en, illegal, mem_req_valid, mem_req_dword;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data, mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pcrel_unit i_pcrel_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_pc(op_pc),
        .op_field(op_field), .op_dst(op_dst), .busy(busy), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .illegal(illegal),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_dword(mem_req_dword), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    typedef struct packed {
        logic [63:0] pc;
        logic [20:0] fld;
        logic [4:0]  dst;
        logic        ill;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_0001_0000, 21'h1E0002, 5'd1,  1'b0, 64'h0000_0000_0003_0000}, // R2
        '{64'h0000_0000_1234_5678, 21'h1EFFFF, 5'd2,  1'b0, 64'h0000_0000_1233_5678}, // R2
        '{64'h0000_0000_1234_5678, 21'h1F0001, 5'd3,  1'b0, 64'h0000_0000_1235_0000}, // R3
        '{64'h0000_0000_0000_8000, 21'h1FFFFF, 5'd4,  1'b0, 64'hFFFF_FFFF_FFFF_0000}, // R3
        '{64'h0000_0000_0000_1000, 21'h000010, 5'd5,  1'b0, 64'h0000_0000_0000_1040}, // R4
        '{64'h0000_0000_0000_1000, 21'h07FFFF, 5'd6,  1'b0, 64'h0000_0000_0000_0FFC}, // R4
        '{64'h0000_0000_0010_0000, 21'h040000, 5'd7,  1'b0, 64'h0000_0000_0000_0000}, // R4
        '{64'h0000_0000_0000_1000, 21'h1C0000, 5'd8,  1'b1, 64'h0},                   // R8
        '{64'h0000_0000_0000_1000, 21'h1D1234, 5'd9,  1'b1, 64'h0}                    // R8
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [63:0] pc, input logic [20:0] fld, input logic [4:0] dst);
        @(negedge clk);
        op_valid = 1'b1; op_pc = pc; op_field = fld; op_dst = dst;
        @(posedge clk); #1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // load: check request, answer after wait_cyc idle cycles, check write
    task automatic do_load(input string req, input logic [63:0] pc, input logic [20:0] fld,
                           input logic [4:0] dst, input logic [63:0] exp_addr,
                           input logic exp_dw, input logic [63:0] rsp,
                           input logic [63:0] exp_data, input int wait_cyc);
        @(negedge clk);
        op_valid = 1'b1; op_pc = pc; op_field = fld; op_dst = dst;
        @(posedge clk); #1;
        chk({req, " req"}, {63'd0, mem_req_valid}, 64'd1);
        chk({req, " addr"}, mem_req_addr, exp_addr);
        chk({req, " size"}, {63'd0, mem_req_dword}, {63'd0, exp_dw});
        chk({req, " busy R9"}, {63'd0, busy}, 64'd1);
        @(negedge clk);
        op_valid = 1'b0;
        for (int i = 0; i < wait_cyc; i++) begin
            @(posedge clk); #1;
            chk({req, " wait busy R9"}, {62'd0, busy, wr_en}, 64'd2);
            @(negedge clk);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = rsp;
        @(posedge clk); #1;
        chk({req, " write R10"}, {63'd0, wr_en}, 64'd1);
        chk({req, " idx R10"}, {59'd0, wr_idx}, {59'd0, dst});
        chk({req, " data"}, wr_data, exp_data);
        chk({req, " busy off R10"}, {63'd0, busy}, 64'd0);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
    endtask

    initial begin
        #40000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", {60'd0, wr_en, illegal, mem_req_valid, busy}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: R2 R3 R4 R8
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            op_valid = 1'b1; op_pc = VECS[v].pc; op_field = VECS[v].fld; op_dst = VECS[v].dst;
            @(posedge clk); #1;
            if (VECS[v].ill) begin
                chk("R8 flags", {61'd0, illegal, wr_en, mem_req_valid}, 64'd4);
            end else begin
                chk("R2/R3/R4 wr", {63'd0, wr_en}, 64'd1);
                chk("R2/R3/R4 idx", {59'd0, wr_idx}, {59'd0, VECS[v].dst});
                chk("R2/R3/R4 data", wr_data, VECS[v].exp);
            end
            @(negedge clk);
            op_valid = 1'b0;
        end

        // R11 no strobe, no write
        @(posedge clk); #1;
        chk("R11", {62'd0, wr_en, illegal}, 64'd0);

        // R5 signed word load
        do_load("R5", 64'h2000, 21'h080003, 5'd10, 64'h200C, 1'b0,
                64'hAAAA_BBBB_8000_0001, 64'hFFFF_FFFF_8000_0001, 2);
        // R6 unsigned word load, negative offset
        do_load("R6", 64'h2000, 21'h17FFFF, 5'd11, 64'h1FFC, 1'b0,
                64'hAAAA_BBBB_8000_0001, 64'h0000_0000_8000_0001, 0);
        // R7 doubleword loads, unaligned PC
        do_load("R7", 64'h2005, 21'h180002, 5'd12, 64'h2010, 1'b1,
                64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567, 1);
        do_load("R7 neg", 64'h2007, 21'h1BFFFF, 5'd13, 64'h1FF8, 1'b1,
                64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 0);

        // R9 strobe while busy is dropped
        @(negedge clk);
        op_valid = 1'b1; op_pc = 64'h3000; op_field = 21'h080000; op_dst = 5'd14;
        @(posedge clk); #1;
        chk("R9 load issued", {63'd0, mem_req_valid}, 64'd1);
        @(negedge clk);
        op_field = 21'h1E0001; op_dst = 5'd15;   // arithmetic form while busy
        @(posedge clk); #1;
        chk("R9 dropped", {60'd0, wr_en, mem_req_valid, illegal, busy}, 64'd1);
        @(negedge clk);
        op_field = 21'h1C0000;                   // bad prefix while busy
        @(posedge clk); #1;
        chk("R9 no illegal", {60'd0, wr_en, mem_req_valid, illegal, busy}, 64'd1);
        @(negedge clk);
        op_valid = 1'b0;
        mem_rsp_valid = 1'b1; mem_rsp_data = 64'h0000_0000_7FFF_FFFF;
        @(posedge clk); #1;
        chk("R10 idx kept", {59'd0, wr_idx}, 64'd14);
        chk("R5 positive", wr_data, 64'h0000_0000_7FFF_FFFF);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        @(posedge clk); #1;
        chk("R11 after load", {62'd0, wr_en, busy}, 64'd0);

        // R1 reset mid-load clears busy
        strobe(64'h4000, 21'h180000, 5'd16);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 reset clears", {60'd0, wr_en, illegal, mem_req_valid, busy}, 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule